// File: doc/BRIEF.md
# Packed Halfword Saturating ALU

This block is a single-stage arithmetic unit for packed data. Each 64-bit source word holds four 16-bit lanes, and each lane is computed on its own with no carry between lanes. A 3-bit operation select picks one of seven lane operations:

- signed-saturating add and subtract;
- mixed-sign saturating add and subtract, with an unsigned first lane, a signed second lane and an unsigned result;
- an average that folds the discarded bit back into the result;
- two scaled adds, where the first lane is shifted left or right by a 2-bit amount before the signed add.

The result is captured in a register on the clock edge that samples the inputs. A datapath pipeline issues one operation per cycle and reads the result one cycle later.

Top module: `phsimd_alu`

## Requirements
- R1: Lanes are independent. Lane k occupies bits [16k+15:16k], and no carry or borrow crosses from one lane to the next.
- R2: Operation code 0 adds both lanes as signed 16-bit values. The sum is clamped to the range -32768 to 32767.
- R3: Operation code 2 subtracts the second lane from the first, both signed, and clamps the result to -32768 to 32767.
- R4: Operation code 1 adds the first lane read as unsigned to the second lane read as signed. The sum is clamped to 0 to 65535.
- R5: Operation code 3 subtracts the signed second lane from the unsigned first lane and clamps the result to 0 to 65535.
- R6: Operation code 4 forms the 17-bit unsigned sum of the two lanes and shifts it right by one. The bit shifted out is ORed into the result's least significant bit.
- R7: Operation code 5 shifts the signed first lane left by the shift amount (0 to 3), adds the signed second lane, and clamps the result to the signed 16-bit range. No wrap occurs before the clamp.
- R8: Operation code 6 shifts the signed first lane right arithmetically by the shift amount (0 to 3), adds the signed second lane, and clamps the result to the signed 16-bit range.
- R9: Operation code 7 produces an all-zero result. The shift amount has no effect on operation codes 0 to 4 and 7.
- R10: The result appears one clock after the inputs are sampled and stays unchanged between edges. While the active-low reset is asserted, the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation code, 0 to 7 |
| shamt | input | 2 | Shift amount for operation codes 5 and 6 |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| result | output | 64 | Registered packed result |

## Verification
The block holds only one result register, so a wrong internal value shows at the ports exactly one cycle after the offending inputs and does not persist after the next edge. Mistakes in the clamp bounds, the sign extension or the lane slicing therefore appear as a wrong lane value at the next sample. Such mistakes surface only for operand pairs near the range limits or with the sign bit set. For that reason the sweep crosses a set of edge values in every lane, for every operation and every shift amount, and offsets the set differently per lane so that neighbouring lanes hold dissimilar data.

// File: rtl/phsimd_pkg.sv
package phsimd_pkg;

    typedef enum logic [2:0] {
        OP_ADD_SS  = 3'd0,
        OP_ADD_US  = 3'd1,
        OP_SUB_SS  = 3'd2,
        OP_SUB_US  = 3'd3,
        OP_AVG     = 3'd4,
        OP_SHL_ADD = 3'd5,
        OP_SHR_ADD = 3'd6,
        OP_NONE    = 3'd7
    } phsimd_op_e;

endpackage

// File: rtl/phsimd_sat.sv
// Clamp a wide signed value into OUT_W bits, signed or unsigned range.
module phsimd_sat #(
    parameter int IN_W  = 21,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  val,
    input  logic                    uns,
    output logic        [OUT_W-1:0] y
);
    localparam logic signed [IN_W-1:0] SMAX = IN_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [IN_W-1:0] SMIN = IN_W'(-(1 << (OUT_W - 1)));
    localparam logic signed [IN_W-1:0] UMAX = IN_W'((1 << OUT_W) - 1);
    localparam logic signed [IN_W-1:0] ZERO = '0;

    always_comb begin
        if (uns) begin
            if (val > UMAX)      y = {OUT_W{1'b1}};
            else if (val < ZERO) y = '0;
            else                 y = val[OUT_W-1:0];
        end else begin
            if (val > SMAX)      y = {1'b0, {(OUT_W-1){1'b1}}};
            else if (val < SMIN) y = {1'b1, {(OUT_W-1){1'b0}}};
            else                 y = val[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/phsimd_lane.sv
// One lane: operand extension, operation select, saturation.
module phsimd_lane
    import phsimd_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int SH_W   = 2
) (
    input  phsimd_op_e          op,
    input  logic [SH_W-1:0]     shamt,
    input  logic [LANE_W-1:0]   a,
    input  logic [LANE_W-1:0]   b,
    output logic [LANE_W-1:0]   y
);
    localparam int MAX_SH = (1 << SH_W) - 1;
    // wide enough for a left shift by MAX_SH plus one add
    localparam int EXT_W  = LANE_W + MAX_SH + 2;

    logic signed [EXT_W-1:0] sa_x, sb_x, ua_x, raw;
    logic                    uns;
    logic [LANE_W:0]         avg_sum;
    logic [LANE_W-1:0]       sat_y;

    assign sa_x    = EXT_W'($signed(a));
    assign sb_x    = EXT_W'($signed(b));
    assign ua_x    = {{(EXT_W-LANE_W){1'b0}}, a};
    assign avg_sum = {1'b0, a} + {1'b0, b};

    always_comb begin
        raw = '0;
        uns = 1'b0;
        case (op)
            OP_ADD_SS:  raw = sa_x + sb_x;
            OP_SUB_SS:  raw = sa_x - sb_x;
            OP_ADD_US:  begin raw = ua_x + sb_x; uns = 1'b1; end
            OP_SUB_US:  begin raw = ua_x - sb_x; uns = 1'b1; end
            OP_SHL_ADD: raw = (sa_x <<< shamt) + sb_x;
            OP_SHR_ADD: raw = (sa_x >>> shamt) + sb_x;
            default:    raw = '0;
        endcase
    end

    phsimd_sat #(.IN_W(EXT_W), .OUT_W(LANE_W)) sat_i (
        .val (raw),
        .uns (uns),
        .y   (sat_y)
    );

    always_comb begin
        case (op)
            OP_AVG:  y = {avg_sum[LANE_W:2], avg_sum[1] | avg_sum[0]};
            OP_NONE: y = '0;
            default: y = sat_y;
        endcase
    end
endmodule

// File: rtl/phsimd_alu.sv
// Packed halfword ALU: LANES parallel lanes, one result register.
module phsimd_alu
    import phsimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16,
    parameter int SH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic [SH_W-1:0]   shamt,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result
);
    localparam int LANES = DATA_W / LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
    } state_t;

    state_t            st_d, st_q;
    phsimd_op_e        op_d;
    logic [DATA_W-1:0] lane_y_d;

    assign op_d = phsimd_op_e'(op_sel);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        phsimd_lane #(.LANE_W(LANE_W), .SH_W(SH_W)) lane_i (
            .op    (op_d),
            .shamt (shamt),
            .a     (src_a[g*LANE_W +: LANE_W]),
            .b     (src_b[g*LANE_W +: LANE_W]),
            .y     (lane_y_d[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.res = lane_y_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;
endmodule

// File: rtl/phsimd_alu_chk.sv
module phsimd_alu_chk #(
    parameter int DATA_W = 64,
    parameter int SH_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_sel,
    input logic [SH_W-1:0]   shamt,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] result
);
    // set once the previous edge was out of reset
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R9
    unused_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_sel) == 3'd7) |-> result == '0);

    // R6
    avg_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_sel) == 3'd4 && $past(src_a) == $past(src_b))
        |-> result == $past(src_a));

    // R3
    sub_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_sel) == 3'd2 && $past(src_a) == $past(src_b))
        |-> result == '0);

    // R2
    add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_sel) == 3'd0 && $past(src_b) == '0)
        |-> result == $past(src_a));

    // R4
    uadd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_sel) == 3'd1 && $past(src_b) == '0)
        |-> result == $past(src_a));

    // R7
    shl_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_sel) == 3'd5 && $past(shamt) == '0 && $past(src_b) == '0)
        |-> result == $past(src_a));
endmodule

bind phsimd_alu phsimd_alu_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_sel (op_sel),
    .shamt  (shamt),
    .src_a  (src_a),
    .src_b  (src_b),
    .result (result)
);

// File: tb/phsimd_alu_test.sv
module phsimd_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  shamt = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    phsimd_alu uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .shamt(shamt),
        .src_a(src_a), .src_b(src_b), .result(result)
    );

    function automatic logic [15:0] edge_val(int k);
        case (k % 16)
            0: return 16'h0000;   1: return 16'h0001;
            2: return 16'h0002;   3: return 16'h0003;
            4: return 16'h7FFF;   5: return 16'h8000;
            6: return 16'h8001;   7: return 16'hFFFF;
            8: return 16'h7FFE;   9: return 16'h4000;
            10: return 16'hC000;  11: return 16'h00FF;
            12: return 16'h1234;  13: return 16'hEDCB;
            14: return 16'h3FFF;  default: return 16'hBFFF;
        endcase
    endfunction

    function automatic int clamp(int v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic logic [15:0] model(int op, int sh, logic [15:0] a, logic [15:0] b);
        int sa = $signed(a);
        int sb = $signed(b);
        int ua = a;
        int ub = b;
        int r;
        case (op)
            0: r = clamp(sa + sb, -32768, 32767);
            1: r = clamp(ua + sb, 0, 65535);
            2: r = clamp(sa - sb, -32768, 32767);
            3: r = clamp(ua - sb, 0, 65535);
            4: begin r = ua + ub; r = (r >> 1) | (r & 1); end
            5: r = clamp(sa * (1 << sh) + sb, -32768, 32767);
            6: r = clamp((sa >>> sh) + sb, -32768, 32767);
            default: r = 0;
        endcase
        return r[15:0];
    endfunction

    function automatic logic [63:0] model64(int op, int sh, logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        for (int l = 0; l < 4; l++)
            r[l*16 +: 16] = model(op, sh, a[l*16 +: 16], b[l*16 +: 16]);
        return r;
    endfunction

    function automatic string tag(int op);
        case (op)
            0: return "R2"; 1: return "R4"; 2: return "R3"; 3: return "R5";
            4: return "R6"; 5: return "R7"; 6: return "R8"; default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b;
        // R10: reset state
        repeat (3) @(negedge clk);
        src_a = 64'h1234_5678_9ABC_DEF0;
        src_b = 64'h1111_2222_3333_4444;
        @(negedge clk);
        check("R10", result, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        op_sel = 3'd0;
        src_a  = 64'h0001_0001_0001_0001;
        src_b  = 64'h0001_0001_0001_0001;
        #1;
        // R10: no change before the edge
        check("R10", result, model64(0, 0, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444));
        @(negedge clk);
        check("R10", result, 64'h0002_0002_0002_0002);

        // R1: lane boundary, no carry or borrow leaks
        src_a = 64'h0000_0000_0000_FFFF; src_b = 64'h0000_0000_0000_0001; op_sel = 3'd0;
        @(negedge clk);
        check("R1", result, 64'h0);
        src_a = 64'h0000_0000_FFFF_FFFF; src_b = 64'h0000_0000_FFFF_FFFF; op_sel = 3'd4;
        @(negedge clk);
        check("R1", result, 64'h0000_0000_FFFF_FFFF);
        src_a = 64'h0000_0000_0000_0000; src_b = 64'h0000_0000_0000_0001; op_sel = 3'd2;
        @(negedge clk);
        check("R1", result, 64'h0000_0000_0000_FFFF);

        // sweep of every operation and shift amount over edge values
        for (int op = 0; op < 8; op++) begin
            for (int sh = 0; sh < 4; sh++) begin
                if (!(op == 5 || op == 6) && sh != 0 && op != 7) continue;
                for (int i = 0; i < 16; i++) begin
                    for (int j = 0; j < 16; j++) begin
                        for (int l = 0; l < 4; l++) begin
                            a[l*16 +: 16] = edge_val(i + l * 5);
                            b[l*16 +: 16] = edge_val(j + l * 3);
                        end
                        op_sel = 3'(op);
                        // R9: shift amount varied where it must be ignored
                        shamt  = (op == 5 || op == 6 || op == 7) ? 2'(sh) : 2'(i + j);
                        src_a  = a;
                        src_b  = b;
                        @(negedge clk);
                        check(tag(op), result, model64(op, sh, a, b));
                    end
                end
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule